// File: doc/BRIEF.md
# Dual-Mode FSK Phase-Accumulator Synthesizer

This block is the digital core of a direct digital synthesizer. A 24-bit phase accumulator advances by a phase increment on every reference clock and wraps modulo 2^24. The top ten phase bits address a quarter-wave sine table. The table produces an offset-binary 11-bit sample, which the block hands to an external DAC. The DAC, the reconstruction filter and the frequency multiplication that follows are outside this block.

Two 22-bit frequency words are held at the inputs. A mode pin picks which of the two sets the increment. When keying is enabled, a transmit-data pin adds four times an 8-bit deviation to the selected word, which gives two-level frequency-shift keying. Every change to the increment is registered before the accumulator uses it. The accumulator is never reloaded, so a change of frequency never causes a jump in phase. An active-low standby input freezes the phase and parks the sample at mid-scale.

Top module: `dds_fsk_synth`

## Requirements
- R1: While reset is asserted and afterwards until the first running cycle, `phase` reads 0 and `sample` reads 1024, which is mid-scale.
- R2: While `standby_n` is 1, each clock adds the registered increment to `phase` modulo 2^24. Overflow past 0xFFFFFF wraps and is not clamped.
- R3: The increment is the selected frequency word zero-extended to 24 bits. `mode_sel` = 0 selects `freq0_word` and `mode_sel` = 1 selects `freq1_word`.
- R4: When `key_off` = 0 and `tx_data` = 1, the increment is the selected word plus `fsk_dev` shifted left by two bits (dev × 4). The sum is taken modulo 2^24.
- R5: When `key_off` = 1, `tx_data` has no effect and the increment equals the selected word.
- R6: An input change sampled at clock edge k alters the increment used at edge k+1. The phase step at edge k still uses the previous increment.
- R7: While running, `sample` at edge k is the offset-binary sine of the phase held before edge k. The quadrant is phase[23:22] and the table address is phase[21:14]. In quadrants 1 and 3 the address is mirrored (255 − addr). The amplitude is 1023·sin(π(2j+1)/1024) to within 3 LSB. Quadrants 0 and 1 output 1024 + amplitude, and quadrants 2 and 3 output 1023 − amplitude. Samples half a cycle apart sum to exactly 2047.
- R8: While `standby_n` is 0, `phase` holds its value and `sample` is 1024 from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| freq0_word | input | 22 | Frequency word used when `mode_sel` is 0 |
| freq1_word | input | 22 | Frequency word used when `mode_sel` is 1 |
| fsk_dev | input | 8 | Keying deviation, applied ×4 |
| mode_sel | input | 1 | Selects which frequency word drives the accumulator |
| key_off | input | 1 | 0 = keying by `tx_data` enabled, 1 = `tx_data` ignored |
| standby_n | input | 1 | Active-low standby: freezes phase, sample at mid-scale |
| tx_data | input | 1 | Transmit data bit that keys the deviation |
| phase | output | 24 | Current accumulator phase |
| sample | output | 11 | Offset-binary sine sample for the DAC |

## Verification
A wrong increment register shows up at `phase` one edge after the bad value is loaded. From then on every step differs from the expected word, so measuring the phase step across a single clock exposes selection, keying and wrap faults within two to three cycles of an input change. A fault in the table or the quadrant logic appears at `sample` one edge after the phase that caused it. The bench therefore compares each sample with a sine model of the previous phase. It also checks the exact 2047 sum between samples half a cycle apart, which isolates mirroring and sign errors from rounding.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Quarter-wave amplitude for table entry k of a qdepth-deep table, scaled to amp.
  // Rational sine approximation on x = pi*(2k+1)/(4*qdepth); pi cancels out.
  function automatic int qsine(input int k, input int qdepth, input int amp);
    longint span;
    longint a;
    longint p;
    longint num;
    longint den;
    span = 4 * longint'(qdepth);
    a    = 2 * longint'(k) + 1;
    p    = a * (span - a);
    num  = 16 * p * longint'(amp);
    den  = 5 * span * span - 4 * p;
    return int'(num / den);
  endfunction

endpackage

// File: rtl/dds_inc_sel.sv
module dds_inc_sel #(
  parameter int ACC_W     = 24,
  parameter int FW        = 22,
  parameter int DEV_W     = 8,
  parameter int DEV_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FW-1:0]    freq0_word,
  input  logic [FW-1:0]    freq1_word,
  input  logic [DEV_W-1:0] fsk_dev,
  input  logic             mode_sel,
  input  logic             key_off,
  input  logic             tx_data,
  output logic [ACC_W-1:0] inc_q
);

  logic [FW-1:0]    word_sel;
  logic [ACC_W-1:0] dev_term;
  logic [ACC_W-1:0] inc_d;

  always_comb begin
    word_sel = mode_sel ? freq1_word : freq0_word;
    dev_term = ACC_W'(fsk_dev) << DEV_SHIFT;
    inc_d    = ACC_W'(word_sel);
    if (!key_off && tx_data) begin
      inc_d = inc_d + dev_term;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q <= '0;
    end else begin
      inc_q <= inc_d;
    end
  end

  // R3
  unkeyed_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_off || !tx_data) |=> (inc_q[ACC_W-1:FW] == '0));

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [ACC_W-1:0] inc,
  output logic [ACC_W-1:0] acc_q
);

  logic [ACC_W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (run) begin
      acc_d = acc_q + inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut #(
  parameter int LUT_AW = 10,
  parameter int DAC_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [LUT_AW-1:0] phase_top,
  output logic [DAC_W-1:0]  sample_q
);

  localparam int Q_AW   = LUT_AW - 2;
  localparam int QDEPTH = 1 << Q_AW;
  localparam int MID    = 1 << (DAC_W - 1);
  localparam int AMP    = MID - 1;

  logic [DAC_W-2:0] qtab [QDEPTH];

  for (genvar gi = 0; gi < QDEPTH; gi++) begin : g_qtab
    localparam int VAL = dds_pkg::qsine(gi, QDEPTH, AMP);
    assign qtab[gi] = VAL[DAC_W-2:0];
  end

  logic [1:0]       quad;
  logic [Q_AW-1:0]  addr;
  logic [Q_AW-1:0]  raddr;
  logic [DAC_W-2:0] amp;
  logic [DAC_W-1:0] samp_d;

  always_comb begin
    quad  = phase_top[LUT_AW-1 -: 2];
    addr  = phase_top[Q_AW-1:0];
    raddr = quad[0] ? ~addr : addr;
    amp   = qtab[raddr];
    if (!run) begin
      samp_d = DAC_W'(MID);
    end else if (quad[1]) begin
      samp_d = DAC_W'(MID - 1) - {1'b0, amp};
    end else begin
      samp_d = DAC_W'(MID) + {1'b0, amp};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= DAC_W'(MID);
    end else begin
      sample_q <= samp_d;
    end
  end

  // R7
  half_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (sample_q[DAC_W-1] == !$past(phase_top[LUT_AW-1])));

  // R8
  standby_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sample_q == DAC_W'(MID)));

endmodule

// File: rtl/dds_fsk_synth.sv
module dds_fsk_synth #(
  parameter int ACC_W  = 24,
  parameter int FW     = 22,
  parameter int DEV_W  = 8,
  parameter int DAC_W  = 11,
  parameter int LUT_AW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FW-1:0]    freq0_word,
  input  logic [FW-1:0]    freq1_word,
  input  logic [DEV_W-1:0] fsk_dev,
  input  logic             mode_sel,
  input  logic             key_off,
  input  logic             standby_n,
  input  logic             tx_data,
  output logic [ACC_W-1:0] phase,
  output logic [DAC_W-1:0] sample
);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [ACC_W-1:0] inc_q;
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[1];

  dds_inc_sel #(
    .ACC_W(ACC_W), .FW(FW), .DEV_W(DEV_W), .DEV_SHIFT(2)
  ) u_inc (
    .clk(clk), .rst_n(rst_sync_n),
    .freq0_word(freq0_word), .freq1_word(freq1_word), .fsk_dev(fsk_dev),
    .mode_sel(mode_sel), .key_off(key_off), .tx_data(tx_data),
    .inc_q(inc_q)
  );

  dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .run(standby_n), .inc(inc_q), .acc_q(acc_q)
  );

  dds_sine_lut #(.LUT_AW(LUT_AW), .DAC_W(DAC_W)) u_lut (
    .clk(clk), .rst_n(rst_sync_n), .run(standby_n),
    .phase_top(acc_q[ACC_W-1 -: LUT_AW]), .sample_q(sample)
  );

  assign phase = acc_q;

  // R2
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    standby_n |=> (phase == $past(phase + inc_q)));

  // R8
  standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !standby_n |=> $stable(phase));

endmodule

// File: tb/tb_dds_fsk_synth.sv
`timescale 1ns/1ps
module tb_dds_fsk_synth;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [21:0] freq0_word, freq1_word;
  logic [7:0]  fsk_dev;
  logic        mode_sel, key_off, standby_n, tx_data;
  logic [23:0] phase;
  logic [10:0] sample;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  dds_fsk_synth dut (
    .clk(clk), .rst_n(rst_n), .freq0_word(freq0_word), .freq1_word(freq1_word),
    .fsk_dev(fsk_dev), .mode_sel(mode_sel), .key_off(key_off),
    .standby_n(standby_n), .tx_data(tx_data), .phase(phase), .sample(sample)
  );

  // {mode_sel, key_off, tx_data, freq0, freq1, dev, expected increment}
  localparam logic [78:0] TBL [8] = '{
    {1'b0, 1'b0, 1'b0, 22'h000100, 22'h000200, 8'h10, 24'h000100},
    {1'b1, 1'b0, 1'b0, 22'h000100, 22'h000200, 8'h10, 24'h000200},
    {1'b0, 1'b0, 1'b1, 22'h000100, 22'h000200, 8'h10, 24'h000140},
    {1'b1, 1'b0, 1'b1, 22'h000100, 22'h000200, 8'hFF, 24'h0005FC},
    {1'b0, 1'b1, 1'b1, 22'h000100, 22'h000200, 8'hFF, 24'h000100},
    {1'b1, 1'b0, 1'b1, 22'h000100, 22'h3FFFFF, 8'hFF, 24'h4003FB},
    {1'b0, 1'b0, 1'b0, 22'h3FFFFF, 22'h000200, 8'hFF, 24'h3FFFFF},
    {1'b1, 1'b1, 1'b0, 22'h000100, 22'h2AAAAA, 8'h33, 24'h2AAAAA}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int sine_model(input logic [23:0] p);
    int  q;
    int  a;
    int  k;
    int  amp;
    real r;
    q   = int'(p[23:22]);
    a   = int'(p[21:14]);
    k   = q[0] ? 255 - a : a;
    r   = 1023.0 * $sin(3.14159265358979 * real'(2 * k + 1) / 1024.0);
    amp = int'(r);
    return q[1] ? 1023 - amp : 1024 + amp;
  endfunction

  task automatic set_cfg(input logic m, input logic ko, input logic tx,
                         input logic [21:0] f0, input logic [21:0] f1, input logic [7:0] d);
    mode_sel = m; key_off = ko; tx_data = tx;
    freq0_word = f0; freq1_word = f1; fsk_dev = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [23:0] p0, p1, inc_e, exp_p;
    logic [10:0] s [4];
    rst_n = 1'b0; standby_n = 1'b0;
    set_cfg(1'b0, 1'b0, 1'b0, 22'h0, 22'h0, 8'h0);
    @(negedge clk);
    // R1: during reset
    check(phase == 24'h0, "R1", phase, 0);
    check(sample == 11'd1024, "R1", sample, 1024);
    cyc(); cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
    check(phase == 24'h0, "R1", phase, 0);
    check(sample == 11'd1024, "R1", sample, 1024);

    // R2/R4: wrap trajectory from zero, increment 0x3FFFFF + 4*0xFF
    set_cfg(1'b0, 1'b0, 1'b1, 22'h3FFFFF, 22'h0, 8'hFF);
    repeat (2) cyc();
    check(phase == 24'h0, "R8", phase, 0);
    standby_n = 1'b1;
    inc_e = 24'h4003FB;
    for (int k = 1; k <= 6; k++) begin
      cyc();
      exp_p = 24'(k * inc_e);
      check(phase == exp_p, "R2", phase, exp_p);
    end

    // R3/R4/R5: table of increments, measured as the phase step
    for (int i = 0; i < 8; i++) begin
      logic [78:0] v;
      v = TBL[i];
      set_cfg(v[78], v[77], v[76], v[75:54], v[53:32], v[31:24]);
      repeat (2) cyc();
      p0 = phase;
      cyc();
      p1 = phase;
      check((p1 - p0) == v[23:0], v[77] ? "R5" : (v[76] ? "R4" : "R3"), p1 - p0, v[23:0]);
    end

    // R6: new increment takes effect one edge late
    set_cfg(1'b0, 1'b0, 1'b0, 22'h000111, 22'h000777, 8'h00);
    repeat (2) cyc();
    p0 = phase;
    mode_sel = 1'b1;
    cyc();
    p1 = phase;
    check((p1 - p0) == 24'h000111, "R6", p1 - p0, 24'h000111);
    cyc();
    check((phase - p1) == 24'h000777, "R6", phase - p1, 24'h000777);

    // R8: standby freezes phase and parks sample
    p0 = phase;
    standby_n = 1'b0;
    cyc();
    check(phase == p0, "R8", phase, p0);
    check(sample == 11'd1024, "R8", sample, 1024);
    mode_sel = 1'b0; tx_data = 1'b1;
    repeat (3) cyc();
    check(phase == p0, "R8", phase, p0);
    check(sample == 11'd1024, "R8", sample, 1024);
    standby_n = 1'b1;

    // R7: sweep, sample compared with model of previous phase
    set_cfg(1'b0, 1'b1, 1'b0, 22'h012345, 22'h0, 8'h0);
    repeat (2) cyc();
    for (int i = 0; i < 300; i++) begin
      int e;
      int d;
      p0 = phase;
      cyc();
      e = sine_model(p0);
      d = int'(sample) - e;
      check(d <= 3 && d >= -3, "R7", sample, e);
    end

    // R7: exact half-cycle symmetry with increment 0x400000 from phase 0
    standby_n = 1'b0;
    rst_n = 1'b0;
    cyc();
    rst_n = 1'b1;
    set_cfg(1'b0, 1'b0, 1'b1, 22'h3FFC04, 22'h0, 8'hFF);
    repeat (4) cyc();
    standby_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cyc();
      s[k] = sample;
    end
    check(phase == 24'h0, "R2", phase, 0);
    check((int'(s[0]) + int'(s[2])) == 2047, "R7", int'(s[0]) + int'(s[2]), 2047);
    check((int'(s[1]) + int'(s[3])) == 2047, "R7", int'(s[1]) + int'(s[3]), 2047);
    check(s[0] > 11'd1024 && s[0] < 11'd1030, "R7", s[0], 1027);
    check(s[1] >= 11'd2045, "R7", s[1], 2046);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule